// File: doc/BRIEF.md
# Circular SRAM Delay Buffer Controller

This controller holds a stream of decoded audio bytes in an external asynchronous byte-wide SRAM run as a ring, so that every byte leaves a fixed time after it arrived. Each transfer request writes one incoming byte at the write pointer and then reads one byte at the read pointer. The read pointer sits a programmable distance behind the write pointer, so the returned byte is the one written that many bytes earlier.

Only the three lowest SRAM address bits are driven in parallel. The upper sixteen go out over a three-wire serial link into two cascaded 8-bit shift-and-hold registers, and are resent only when the upper part of the target address changes. The pointer distance is worked out from a delay setting in 10 ms steps and from the spacing of fill ticks, one per stored block, counted in cycles of the block clock, which serves as the time reference. A toggle input switches between zero delay and the stored delay.

Top module: `ring_delay_ctl`

## Requirements
- R1: The write address starts at 0, rises by one per transfer and wraps to 0 after the byte at NUM_BLK*BLK_BYTES-1. The read pointer follows the same rule.
- R2: A transfer writes `xfer_wdata` first and then reads. After an offset of D bytes has been applied and at least D further bytes written, the data returned is the byte written D transfers before the current one. With D = 0 it is the byte just written.
- R3: The offset in blocks is floor(steps * STEP_REF / period), limited to NUM_BLK-1, and D = blocks * BLK_BYTES. Here period is the number of clock cycles between two consecutive `fill_tick` pulses.
- R4: Values of `delay_steps` below STEPS_MIN act as STEPS_MIN, and values above STEPS_MAX act as STEPS_MAX. A new setting that clamps to the value already in use changes nothing.
- R5: When the clamped setting or the measured period changes, the offset is recomputed and the read pointer is placed at the write pointer minus D, modulo the ring size. No offset is applied until two ticks have been seen.
- R6: Address bits 18..3 are sent most significant bit first. `ser_dat` changes only while `ser_clk` is low and is taken on its rising edge, and `ser_lat` is low for the whole shift. The rising edge of `ser_lat` moves the 16 shifted bits to the address lines: the first eight sent drive bits 18..11 and the last eight drive bits 10..3.
- R7: No serial reload happens when the upper address bits of an access match those already latched. In bypass the latch therefore rises exactly once per transfer whose write address is a multiple of 8, and not otherwise.
- R8: `sram_we_n` is low only while writing and `sram_oe_n` only while reading, never both at once. `sram_ce_n` is low whenever either of them is low. Address and write data stay stable while `sram_we_n` is low and through the cycle after it rises.
- R9: A `bypass_tgl` pulse inverts `bypass_on`. In bypass D = 0. Leaving bypass restores the last computed offset without a new measurement.
- R10: `filling` is high from the moment an offset is applied until D bytes have been written after it.
- R11: `xfer_done` is a one-cycle pulse per transfer, carrying `xfer_rdata`. After reset both strobes and `sram_ce_n` are high, `ser_lat` is high, `ser_clk` is low, and `xfer_done`, `bypass_on` and `filling` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the time reference for the rate measurement |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req | input | 1 | Start one write-then-read transfer (accepted when idle) |
| xfer_wdata | input | DATA_W | Byte to store |
| xfer_done | output | 1 | Transfer finished, read byte valid |
| xfer_rdata | output | DATA_W | Delayed byte |
| fill_tick | input | 1 | One pulse per incoming block |
| delay_steps | input | STEPS_W | Delay in 10 ms units |
| bypass_tgl | input | 1 | Pulse: toggle zero-delay mode |
| bypass_on | output | 1 | Zero-delay mode active |
| filling | output | 1 | Offset applied but not yet filled |
| sram_alo | output | LO_W | Parallel low address bits |
| sram_dq_o | output | DATA_W | Write data to SRAM |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | DATA_W | Read data from SRAM |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_ce_n | output | 1 | Active-low chip enable |
| ser_clk | output | 1 | Serial address shift clock |
| ser_dat | output | 1 | Serial address data |
| ser_lat | output | 1 | Serial address latch (rising edge transfers) |

## Verification
The hardest case to reach is a re-placement of the read pointer caused by a change in the measured input rate alone. It only happens after the tick spacing has settled, and the effect shows only in which bytes come back. The bench drives the fill ticks from a generator with an adjustable spacing and changes that spacing while the transfer stream is paused. It then streams far enough past the new offset to compare every byte against its own history. Clamping to the largest offset and reinstating the offset after bypass are reached the same way, with streams long enough to wrap the ring.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic [2:0] {
    XS_IDLE, XS_WSH, XS_WR, XS_WEND, XS_RSH, XS_RD
  } xfer_st_t;

  typedef enum logic [1:0] {
    SH_IDLE, SH_HI, SH_LO
  } sh_st_t;
endpackage

// File: rtl/rdc_rate_meter.sv
module rdc_rate_meter #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [PER_W-1:0] period,
  output logic             valid,
  output logic             chg
);
  logic [PER_W-1:0] cnt;
  logic             seen;
  logic [PER_W-1:0] span;

  assign span = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      seen   <= 1'b0;
      period <= '0;
      valid  <= 1'b0;
      chg    <= 1'b0;
    end else begin
      chg <= 1'b0;
      if (tick) begin
        cnt  <= '0;
        seen <= 1'b1;
        if (seen) begin
          period <= span;
          valid  <= 1'b1;
          if (!valid || span != period) chg <= 1'b1;
        end
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdc_divider.sv
module rdc_divider #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] left;
  logic [DEN_W:0]   trial;
  logic             take;

  assign trial = {rem[DEN_W-1:0], quo[NUM_W-1]};
  assign take  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      quo   <= '0;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        den_q <= den;
        quo   <= num;
        left  <= CNT_W'(NUM_W);
      end else if (left != '0) begin
        rem  <= take ? trial - {1'b0, den_q} : trial;
        quo  <= {quo[NUM_W-2:0], take};
        left <= left - 1'b1;
        if (left == CNT_W'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdc_addr_shifter.sv
module rdc_addr_shifter
  import rdc_pkg::*;
#(
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [HI_W-1:0] value,
  output logic            ser_clk,
  output logic            ser_dat,
  output logic            ser_lat,
  output logic            done
);
  localparam int BC_W = $clog2(HI_W);

  sh_st_t          st;
  logic [HI_W-1:0] sr;
  logic [BC_W-1:0] bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      sr      <= '0;
      bitn    <= '0;
      ser_clk <= 1'b0;
      ser_dat <= 1'b0;
      ser_lat <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: if (start) begin
          sr      <= value;
          ser_dat <= value[HI_W-1];
          ser_lat <= 1'b0;
          bitn    <= '0;
          st      <= SH_HI;
        end
        SH_HI: begin
          ser_clk <= 1'b1;
          st      <= SH_LO;
        end
        SH_LO: begin
          ser_clk <= 1'b0;
          if (bitn == BC_W'(HI_W - 1)) begin
            ser_lat <= 1'b1;
            done    <= 1'b1;
            st      <= SH_IDLE;
          end else begin
            sr      <= sr << 1;
            ser_dat <= sr[HI_W-2];
            bitn    <= bitn + 1'b1;
            st      <= SH_HI;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_delay_ctl.sv
module ring_delay_ctl
  import rdc_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int LO_W      = 3,
  parameter int DATA_W    = 8,
  parameter int NUM_BLK   = 4680,
  parameter int BLK_BYTES = 112,
  parameter int STEP_REF  = 400000,
  parameter int STEPS_W   = 8,
  parameter int STEPS_MIN = 2,
  parameter int STEPS_MAX = 150,
  parameter int PER_W     = 24,
  parameter int WR_CYC    = 2,
  parameter int RD_CYC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_req,
  input  logic [DATA_W-1:0]  xfer_wdata,
  output logic               xfer_done,
  output logic [DATA_W-1:0]  xfer_rdata,
  input  logic               fill_tick,
  input  logic [STEPS_W-1:0] delay_steps,
  input  logic               bypass_tgl,
  output logic               bypass_on,
  output logic               filling,
  output logic [LO_W-1:0]    sram_alo,
  output logic [DATA_W-1:0]  sram_dq_o,
  output logic               sram_dq_oe,
  input  logic [DATA_W-1:0]  sram_dq_i,
  output logic               sram_we_n,
  output logic               sram_oe_n,
  output logic               sram_ce_n,
  output logic               ser_clk,
  output logic               ser_dat,
  output logic               ser_lat
);
  localparam int HI_W   = ADDR_W - LO_W;
  localparam int TOTAL  = NUM_BLK * BLK_BYTES;
  localparam int REF_W  = $clog2(STEP_REF + 1);
  localparam int NUM_W  = STEPS_W + REF_W;
  localparam int BIDX_W = $clog2(NUM_BLK);
  localparam int CYC_W  = 4;

  // ring arithmetic, kept in functions so the bench can restate it
  function automatic logic [ADDR_W-1:0] ptr_inc(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(TOTAL - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_back(input logic [ADDR_W-1:0] p,
                                                 input logic [ADDR_W-1:0] d);
    return (p >= d) ? p - d : p + ADDR_W'(TOTAL) - d;
  endfunction

  function automatic logic [STEPS_W-1:0] clamp_steps(input logic [STEPS_W-1:0] s);
    if (s < STEPS_W'(STEPS_MIN)) return STEPS_W'(STEPS_MIN);
    if (s > STEPS_W'(STEPS_MAX)) return STEPS_W'(STEPS_MAX);
    return s;
  endfunction

  function automatic logic [BIDX_W-1:0] clamp_blocks(input logic [NUM_W-1:0] q);
    return (q > NUM_W'(NUM_BLK - 1)) ? BIDX_W'(NUM_BLK - 1) : BIDX_W'(q);
  endfunction

  function automatic logic [ADDR_W-1:0] blk_bytes(input logic [BIDX_W-1:0] b);
    return ADDR_W'(b) * ADDR_W'(BLK_BYTES);
  endfunction

  // rate measurement and offset division
  logic [PER_W-1:0]   period;
  logic               rate_valid, rate_chg;
  logic [STEPS_W-1:0] steps_q, steps_cl;
  logic [NUM_W-1:0]   div_num, div_quo;
  logic               div_start, div_done;
  logic [BIDX_W-1:0]  blk_q;

  assign steps_cl  = clamp_steps(delay_steps);
  assign div_num   = NUM_W'(steps_cl) * NUM_W'(STEP_REF);
  assign div_start = rate_valid && (rate_chg || steps_cl != steps_q);

  rdc_rate_meter #(.PER_W(PER_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .tick(fill_tick),
    .period(period), .valid(rate_valid), .chg(rate_chg)
  );

  rdc_divider #(.NUM_W(NUM_W), .DEN_W(PER_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
    .den(period), .quo(div_quo), .done(div_done)
  );

  // serial upper address
  logic            sh_start, sh_done;
  logic [HI_W-1:0] sh_val, lat_hi;
  logic            lat_ok;

  rdc_addr_shifter #(.HI_W(HI_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .value(sh_val),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat), .done(sh_done)
  );

  // transfer engine
  xfer_st_t          st;
  logic [ADDR_W-1:0] wp, rp, need_q, fill_cnt, off_bytes;
  logic [DATA_W-1:0] wbuf;
  logic [CYC_W-1:0]  cyc;
  logic              apply_pend;
  logic              ev_apply, ev_wr_commit;

  assign off_bytes    = bypass_on ? '0 : blk_bytes(blk_q);
  assign ev_apply     = (st == XS_IDLE) && apply_pend;
  assign ev_wr_commit = (st == XS_WEND);
  assign filling      = fill_cnt < need_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q    <= '0;
      blk_q      <= '0;
      bypass_on  <= 1'b0;
      apply_pend <= 1'b0;
    end else begin
      if (steps_cl != steps_q) steps_q <= steps_cl;
      if (div_done) blk_q <= clamp_blocks(div_quo);
      if (bypass_tgl) bypass_on <= ~bypass_on;
      apply_pend <= (apply_pend && !ev_apply) || div_done || bypass_tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= XS_IDLE;
      wp         <= '0;
      rp         <= '0;
      need_q     <= '0;
      fill_cnt   <= '0;
      wbuf       <= '0;
      cyc        <= '0;
      lat_hi     <= '0;
      lat_ok     <= 1'b0;
      sh_start   <= 1'b0;
      sh_val     <= '0;
      xfer_done  <= 1'b0;
      xfer_rdata <= '0;
    end else begin
      sh_start  <= 1'b0;
      xfer_done <= 1'b0;
      case (st)
        XS_IDLE: begin
          if (apply_pend) begin
            rp       <= ptr_back(wp, off_bytes);
            need_q   <= off_bytes;
            fill_cnt <= '0;
          end else if (xfer_req) begin
            wbuf <= xfer_wdata;
            cyc  <= '0;
            if (lat_ok && lat_hi == wp[ADDR_W-1:LO_W]) begin
              st <= XS_WR;
            end else begin
              sh_start <= 1'b1;
              sh_val   <= wp[ADDR_W-1:LO_W];
              lat_ok   <= 1'b0;
              st       <= XS_WSH;
            end
          end
        end
        XS_WSH: if (sh_done) begin
          lat_hi <= sh_val;
          lat_ok <= 1'b1;
          st     <= XS_WR;
        end
        XS_WR: begin
          if (cyc == CYC_W'(WR_CYC - 1)) st <= XS_WEND;
          else cyc <= cyc + 1'b1;
        end
        XS_WEND: begin
          wp  <= ptr_inc(wp);
          cyc <= '0;
          if (fill_cnt < need_q) fill_cnt <= fill_cnt + 1'b1;
          if (lat_ok && lat_hi == rp[ADDR_W-1:LO_W]) begin
            st <= XS_RD;
          end else begin
            sh_start <= 1'b1;
            sh_val   <= rp[ADDR_W-1:LO_W];
            lat_ok   <= 1'b0;
            st       <= XS_RSH;
          end
        end
        XS_RSH: if (sh_done) begin
          lat_hi <= sh_val;
          lat_ok <= 1'b1;
          st     <= XS_RD;
        end
        XS_RD: begin
          if (cyc == CYC_W'(RD_CYC - 1)) begin
            xfer_rdata <= sram_dq_i;
            xfer_done  <= 1'b1;
            rp         <= ptr_inc(rp);
            st         <= XS_IDLE;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  assign sram_we_n  = !(st == XS_WR);
  assign sram_oe_n  = !(st == XS_RD);
  assign sram_ce_n  = sram_we_n & sram_oe_n;
  assign sram_dq_oe = (st == XS_WR) || (st == XS_WEND);
  assign sram_dq_o  = wbuf;
  assign sram_alo   = (st == XS_RSH || st == XS_RD) ? rp[LO_W-1:0] : wp[LO_W-1:0];
endmodule

// File: rtl/ring_delay_ctl_chk.sv
module ring_delay_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int LO_W   = 3,
  parameter int DATA_W = 8,
  parameter int TOTAL  = 524160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_ce_n,
  input logic [LO_W-1:0]   sram_alo,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              ser_clk,
  input logic              ser_lat,
  input logic              xfer_done,
  input logic              bypass_tgl,
  input logic              bypass_on,
  input logic              filling,
  input logic              ev_apply,
  input logic              ev_wr_commit,
  input logic [ADDR_W-1:0] wp,
  input logic [ADDR_W-1:0] rp
);
  p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wp < ADDR_W'(TOTAL)) && (rp < ADDR_W'(TOTAL)));

  p_wr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_commit |=> (wp == (($past(wp) == ADDR_W'(TOTAL - 1)) ? '0 : $past(wp) + 1'b1)));

  p_no_dual_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  p_ce_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  p_ce_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_ce_n);

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> ($stable(sram_alo) && $stable(sram_dq_o)));

  p_access_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n || !sram_oe_n) |-> ser_lat);

  p_lat_rise_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_lat) |-> !ser_clk);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_bypass_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_tgl |=> (bypass_on != $past(bypass_on)));

  p_bypass_no_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_apply && bypass_on) |=> !filling);
endmodule

bind ring_delay_ctl ring_delay_ctl_chk #(
  .ADDR_W(ADDR_W), .LO_W(LO_W), .DATA_W(DATA_W), .TOTAL(NUM_BLK * BLK_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
  .sram_ce_n(sram_ce_n), .sram_alo(sram_alo), .sram_dq_o(sram_dq_o),
  .ser_clk(ser_clk), .ser_lat(ser_lat), .xfer_done(xfer_done),
  .bypass_tgl(bypass_tgl), .bypass_on(bypass_on), .filling(filling),
  .ev_apply(ev_apply), .ev_wr_commit(ev_wr_commit), .wp(wp), .rp(rp)
);

// File: tb/sim_ring_delay_ctl.sv
module sim_ring_delay_ctl;
  localparam int NB    = 20;
  localparam int BB    = 16;
  localparam int SREF  = 32;
  localparam int TOT   = NB * BB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_req = 1'b0;
  logic [7:0] xfer_wdata = '0;
  logic       xfer_done;
  logic [7:0] xfer_rdata;
  logic       fill_tick = 1'b0;
  logic [7:0] delay_steps = 8'd2;
  logic       bypass_tgl = 1'b0;
  logic       bypass_on, filling;
  logic [2:0] sram_alo;
  logic [7:0] sram_dq_o, sram_dq_i;
  logic       sram_dq_oe, sram_we_n, sram_oe_n, sram_ce_n;
  logic       ser_clk, ser_dat, ser_lat;

  always #5 clk = ~clk;

  ring_delay_ctl #(.NUM_BLK(NB), .BLK_BYTES(BB), .STEP_REF(SREF)) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_wdata(xfer_wdata),
    .xfer_done(xfer_done), .xfer_rdata(xfer_rdata), .fill_tick(fill_tick),
    .delay_steps(delay_steps), .bypass_tgl(bypass_tgl), .bypass_on(bypass_on),
    .filling(filling), .sram_alo(sram_alo), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ce_n(sram_ce_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ser_lat(ser_lat)
  );

  // behavioural SRAM plus two cascaded shift/hold registers
  logic [15:0] m_shift = '0;
  logic [15:0] m_hold  = '0;
  logic [7:0]  mem [0:1023];
  logic [18:0] m_addr;
  logic [18:0] last_waddr = '0;
  int          lat_edges = 0;
  int          n_vec = 0;
  int          n_bad = 0;

  assign m_addr    = {m_hold, sram_alo};
  assign sram_dq_i = mem[m_addr[9:0]];

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

  always @(posedge ser_clk) if (rst_n) m_shift <= {m_shift[14:0], ser_dat};
  always @(posedge ser_lat) if (rst_n) begin
    m_hold    <= m_shift;
    lat_edges <= lat_edges + 1;
  end
  always @(posedge sram_we_n) if (rst_n) begin
    mem[m_addr[9:0]] <= sram_dq_o;
    last_waddr       <= m_addr;
    n_vec++;
    if (!sram_dq_oe) begin
      n_bad++;
      $display("FAIL R8 data bus not driven at write end: oe=%0d exp=1", sram_dq_oe);
    end
  end

  // fill tick generator with adjustable spacing
  int tick_per = 32;
  initial begin
    @(posedge rst_n);
    forever begin
      repeat (tick_per - 1) @(negedge clk);
      fill_tick = 1'b1;
      @(negedge clk);
      fill_tick = 1'b0;
    end
  end

  // bench bookkeeping
  logic [7:0] hist [0:1023];
  int xcount = 0;
  int bwp = 0;
  int apply_idx = 0;
  int exp_d = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bytes(input int steps, input int per);
    int s = steps < 2 ? 2 : (steps > 150 ? 150 : steps);
    int b = (s * SREF) / per;
    if (b > NB - 1) b = NB - 1;
    return b * BB;
  endfunction

  task automatic do_xfer(input logic [7:0] d, output logic [7:0] r, output bit ok);
    int guard = 0;
    ok = 1'b1;
    @(negedge clk);
    xfer_wdata = d;
    xfer_req   = 1'b1;
    @(negedge clk);
    xfer_req   = 1'b0;
    while (!xfer_done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (!xfer_done) begin
      ok = 1'b0;
      chk(1'b0, "R11 transfer never completed", 0, 1);
    end
    r = xfer_rdata;
  endtask

  task automatic t_stream(input int n, input string tag, input bit edge_chk);
    logic [7:0] r;
    bit         ok;
    int         k, e0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'((xcount * 7 + 3) ^ (xcount >> 3));
      hist[xcount] = d;
      e0 = lat_edges;
      do_xfer(d, r, ok);
      if (!ok) return;
      chk(last_waddr == 19'(bwp), {"R1/R6 write address ", tag}, int'(last_waddr), bwp);
      k = xcount - apply_idx + 1;
      if (k - 1 >= exp_d)
        chk(r == hist[xcount - exp_d], {"R2 delayed byte ", tag}, int'(r),
            int'(hist[xcount - exp_d]));
      chk(filling == (k < exp_d), {"R10 filling ", tag}, int'(filling), int'(k < exp_d));
      if (edge_chk && i > 0)
        chk((lat_edges - e0) == ((bwp % 8) == 0 ? 1 : 0), {"R7 reload count ", tag},
            lat_edges - e0, (bwp % 8) == 0 ? 1 : 0);
      bwp = (bwp + 1) % TOT;
      xcount++;
    end
  endtask

  task automatic t_reset;
    chk(sram_we_n && sram_oe_n && sram_ce_n, "R11 strobes idle after reset",
        {sram_we_n, sram_oe_n, sram_ce_n}, 7);
    chk(ser_lat && !ser_clk, "R11 serial lines after reset", {ser_lat, ser_clk}, 2);
    chk(!xfer_done && !bypass_on && !filling, "R11 flags after reset",
        {xfer_done, bypass_on, filling}, 0);
  endtask

  task automatic t_first_offset;
    repeat (200) @(negedge clk);
    apply_idx = xcount;
    exp_d = exp_bytes(2, 32);
    t_stream(80, "R3 first offset", 1'b0);
  endtask

  task automatic t_clamp_low;
    delay_steps = 8'd0;
    repeat (100) @(negedge clk);
    t_stream(40, "R4 low clamp keeps offset", 1'b0);
  endtask

  task automatic t_new_steps;
    delay_steps = 8'd3;
    repeat (100) @(negedge clk);
    apply_idx = xcount;
    exp_d = exp_bytes(3, 32);
    t_stream(80, "R5 new steps", 1'b0);
  endtask

  task automatic t_rate_change;
    tick_per = 64;
    repeat (400) @(negedge clk);
    apply_idx = xcount;
    exp_d = exp_bytes(3, 64);
    t_stream(50, "R5 rate change", 1'b0);
  endtask

  task automatic t_clamp_high;
    delay_steps = 8'd200;
    repeat (100) @(negedge clk);
    apply_idx = xcount;
    exp_d = exp_bytes(200, 64);
    chk(exp_d == (NB - 1) * BB, "R3 block limit", exp_d, (NB - 1) * BB);
    t_stream(330, "R4 high clamp and R1 wrap", 1'b0);
  endtask

  task automatic t_bypass;
    delay_steps = 8'd2;
    repeat (100) @(negedge clk);
    apply_idx = xcount;
    exp_d = exp_bytes(2, 64);
    t_stream(30, "R3 short offset", 1'b0);
    bypass_tgl = 1'b1;
    @(negedge clk);
    bypass_tgl = 1'b0;
    repeat (20) @(negedge clk);
    chk(bypass_on, "R9 bypass entered", int'(bypass_on), 1);
    apply_idx = xcount;
    exp_d = 0;
    t_stream(20, "R9 zero delay", 1'b1);
    bypass_tgl = 1'b1;
    @(negedge clk);
    bypass_tgl = 1'b0;
    repeat (20) @(negedge clk);
    chk(!bypass_on, "R9 bypass left", int'(bypass_on), 0);
    apply_idx = xcount;
    exp_d = exp_bytes(2, 64);
    t_stream(40, "R9 offset reinstated", 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_first_offset();
    t_clamp_low();
    t_new_steps();
    t_rate_change();
    t_clamp_high();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", xcount, 670);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule